// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Selectable Parity and Stop Length

This block turns parallel words into frames on one serial output line. A word enters through a valid/ready handshake. The block then drives a start bit, the data bits with the least significant bit first, an optional parity bit and one or two stop periods. One bit time is a whole number of system clock cycles. That number is worked out at elaboration from the clock frequency and the target baud rate. While nothing is being sent, the line rests at logic 1. A busy flag is high for the whole frame.

The bit timer is not free-running. It restarts when a word is accepted, so a new frame can begin on any clock cycle once the previous stop time has run out. It does not wait for a fixed baud grid. Parity mode and stop length are static settings. They are read while a frame is being sent and must stay constant during it.

The control logic is a five-state machine:
- IDLE: the line is 1 and ready is high. IDLE goes to START when a word is accepted.
- START: the line is 0. START goes to DATA at the end of the bit time.
- DATA: the line carries the current data bit. After each bit time DATA either moves to the next bit or, after the last bit, goes to PARITY when parity is enabled and to STOP otherwise.
- PARITY: the line carries the parity bit. PARITY goes to STOP after one bit time.
- STOP: the line is 1. STOP either counts another stop period or returns to IDLE after the last one.

A synchronous reset forces IDLE from any state.

Top module: `sertx_top`

## Requirements
- R1: After reset, and between frames, `tx` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `tx` is 0 for exactly one bit time (the start bit) and `busy` is 1.
- R3: The DATA_W data bits follow the start bit, bit 0 first. Each bit lasts one bit time. The values sent are those present on `in_data` at acceptance; later changes on `in_data` have no effect on the frame.
- R4: `par_mode` selects the parity:
  - 2'b00: no parity bit.
  - 2'b01: even parity. One parity bit follows the data and makes the number of ones across data plus parity even.
  - 2'b10: odd parity. The parity bit makes that number odd.
  - 2'b11: behaves exactly as 2'b00.
- R5: After the last data or parity bit, `tx` is 1 for one bit time when `stop_two`=0 and for two bit times when `stop_two`=1. `in_ready` returns to 1 in the cycle right after the stop time ends.
- R6: `in_ready` is 0 from the cycle after acceptance until the stop time ends. `in_valid` raised while `in_ready` is 0 is ignored, unless the source still holds it when `in_ready` returns. A word held by its source is accepted at the first edge where `in_ready` is 1, so its start bit begins one cycle after the previous stop time.
- R7: One bit time is CLKS_PER_BIT clock cycles, where CLKS_PER_BIT is CLK_HZ / BAUD rounded to the nearest integer.
- R8: Reset is synchronous and active high. A reset asserted in the middle of a frame returns `tx` to 1, `in_ready` to 1 and `busy` to 0 on the next clock edge, with nothing of the old frame sent afterwards.
- R9: With no parity and one stop bit, sending 8'h41 twice back to back gives line bits, sampled at mid-bit, of 0100000101 followed by 0100000101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Word to transmit |
| in_valid | input | 1 | Source offers `in_data` |
| in_ready | output | 1 | Block can accept a word on this edge |
| par_mode | input | 2 | Parity: 00 none, 01 even, 10 odd, 11 none |
| stop_two | input | 1 | 0: one stop period, 1: two stop periods |
| tx | output | 1 | Serial output line, idle high |
| busy | output | 1 | A frame is in progress |

## Verification
The bench holds `in_valid` high across a frame while changing `in_data`, so two kinds of fault become visible: a design that does not latch the word would send corrupted data bits, and one that accepts while busy would start a frame in the middle of another. A lone `in_valid` pulse during a busy frame checks that stray requests are dropped rather than queued. Starting a frame while the block is idle between words checks that timing restarts at acceptance; a design tied to a fixed baud grid would stretch or shorten the start bit. The even, odd, reserved and two-stop settings each catch a parity bit that is inverted, missing or extra, or a stop time that is one bit time short. A reset in the middle of a frame exposes leftover bit counts or leftover shift register content.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } sertx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } sertx_par_e;

    // Nearest-integer division used to size one bit time (R7).
    function automatic int unsigned div_round(longint unsigned num, longint unsigned den);
        return int'((num + den / 2) / den);
    endfunction

endpackage

// File: rtl/sertx_baud_timer.sv
module sertx_baud_timer #(
    parameter int unsigned CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic bit_end
);
    localparam int unsigned CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    // Counter restarts whenever the FSM is idle, so a frame starts on any cycle.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_end = run && (cnt_q == LAST);

    // R7: after the last cycle of a bit the count begins again from zero.
    assert_bit_restart_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(bit_end) && run) |-> (cnt_q == '0));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic              odd,
    input  logic [DATA_W-1:0] din,
    output logic              lsb,
    output logic              par_bit
);
    logic [DATA_W-1:0] sh_q;
    logic              par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= din;
            par_q <= (^din) ^ odd;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
        end
    end

    assign lsb     = sh_q[0];
    assign par_bit = par_q;

    // R3: a word is never captured in the same cycle as a data bit advances.
    assert_load_shift_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic bit_end,
    input  logic par_en,
    input  logic stop_two,
    input  logic lsb,
    input  logic par_bit,
    output logic tx,
    output logic in_ready,
    output logic busy,
    output logic load,
    output logic shift
);
    localparam int unsigned IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    sertx_state_e  state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [IW-1:0] last_stop;

    assign last_stop = stop_two ? IW'(1) : '0;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_START;
                    idx_d   = '0;
                end
            end
            ST_START: begin
                if (bit_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (idx_q == LAST_IDX) begin
                        idx_d   = '0;
                        state_d = par_en ? ST_PARITY : ST_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (idx_q == last_stop) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx       = 1'b1;
        in_ready = 1'b0;
        busy     = 1'b1;
        load     = 1'b0;
        shift    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                busy     = 1'b0;
                load     = in_valid;
            end
            ST_START:  tx = 1'b0;
            ST_DATA: begin
                tx    = lsb;
                shift = bit_end;
            end
            ST_PARITY: tx = par_bit;
            ST_STOP:   tx = 1'b1;
            default:   tx = 1'b1;
        endcase
    end

    // R2: acceptance is followed by the start bit and a dropped ready.
    assert_start_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!in_ready && !tx));

    // R5: ready only comes back after a full bit time with the line high.
    assert_stop_before_ready_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(in_ready) && !$past(rst)) |-> ($past(tx) && $past(bit_end)));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CLK_HZ = 125_000_000,
    parameter int unsigned BAUD   = 115_200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        par_mode,
    input  logic              stop_two,
    output logic              tx,
    output logic              busy
);
    localparam int unsigned CLKS_PER_BIT = div_round(CLK_HZ, BAUD);

    logic bit_end, load, shift, lsb, par_bit, par_en, odd;

    assign par_en = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
    assign odd    = (par_mode == PAR_ODD);

    sertx_baud_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .bit_end (bit_end)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .shift   (shift),
        .odd     (odd),
        .din     (in_data),
        .lsb     (lsb),
        .par_bit (par_bit)
    );

    sertx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .bit_end  (bit_end),
        .par_en   (par_en),
        .stop_two (stop_two),
        .lsb      (lsb),
        .par_bit  (par_bit),
        .tx       (tx),
        .in_ready (in_ready),
        .busy     (busy),
        .load     (load),
        .shift    (shift)
    );

    // R3: inside a bit time the line level does not move.
    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_end) |=> $stable(tx));

    // R6: no acceptance is possible while a frame is in progress.
    assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    localparam int unsigned DW     = 8;
    localparam int unsigned CLK_HZ = 125_000_000;
    localparam int unsigned BAUD   = 15_625_000;
    localparam int unsigned CPB    = (CLK_HZ + BAUD / 2) / BAUD;  // R7

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic [1:0]    par_mode = 2'b00;
    logic          stop_two = 1'b0;
    logic          in_ready, tx, busy;

    always #4 clk = ~clk;

    sertx_top #(.DATA_W(DW), .CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .par_mode(par_mode), .stop_two(stop_two),
        .tx(tx), .busy(busy)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: a queue of line levels, one entry per clock cycle.
    bit q_bit[$];
    int q_tag[$];
    bit exp_tx  = 1'b1;
    int exp_tag = 1;
    bit exp_rdy = 1'b1;
    bit model_live = 1'b0;

    function automatic void push_level(bit v, int tag);
        for (int c = 0; c < int'(CPB); c++) begin
            q_bit.push_back(v);
            q_tag.push_back(tag);
        end
    endfunction

    function automatic void push_frame(logic [DW-1:0] d);
        int ones = 0;
        push_level(1'b0, 2);
        for (int b = 0; b < DW; b++) begin
            push_level(d[b], 3);
            ones += int'(d[b]);
        end
        if (par_mode == 2'b01) push_level((ones % 2) == 1, 4);
        if (par_mode == 2'b10) push_level((ones % 2) == 0, 4);
        push_level(1'b1, 5);
        if (stop_two) push_level(1'b1, 5);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q_bit.delete();
            q_tag.delete();
        end else begin
            bit acc;
            acc = in_valid && exp_rdy;
            if (q_bit.size() > 0) begin
                void'(q_bit.pop_front());
                void'(q_tag.pop_front());
            end
            if (acc) push_frame(in_data);
        end
        if (q_bit.size() > 0) begin
            exp_tx  = q_bit[0];
            exp_tag = q_tag[0];
        end else begin
            exp_tx  = 1'b1;
            exp_tag = 1;
        end
        exp_rdy    = (q_bit.size() == 0);
        model_live = 1'b1;
    end

    always @(negedge clk) begin
        if (model_live && !done) begin
            chk($sformatf("R%0d", exp_tag), tx, exp_tx, "tx per cycle");
            chk("R6", in_ready, exp_rdy, "in_ready per cycle");
            chk("R1", busy, !exp_rdy, "busy per cycle");
        end
    end

    // Mid-bit sampler
    bit cap_en = 1'b0;
    bit cap_q[$];
    int sm_left = 0;
    int sm_cnt  = 0;
    int sm_len  = 10;

    always @(negedge clk) begin
        if (cap_en) begin
            if (sm_left == 0) begin
                if (tx == 1'b0) begin
                    sm_left = sm_len;
                    sm_cnt  = CPB / 2;
                end
            end else begin
                sm_cnt--;
                if (sm_cnt == 0) begin
                    cap_q.push_back(tx);
                    sm_left--;
                    sm_cnt = CPB;
                end
            end
        end
    end

    task automatic send(logic [DW-1:0] d);
        in_data  = d;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_parity(bit odd_mode, int frames);
        for (int f = 0; f < frames; f++) begin
            int ones = 0;
            for (int b = 1; b <= DW + 1; b++) ones += int'(cap_q[f * 11 + b]);
            chk("R4", ones % 2, odd_mode ? 1 : 0, "decoded parity");
        end
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", tx, 1'b1, "tx in reset");
        chk("R1", in_ready, 1'b1, "ready in reset");
        chk("R1", busy, 1'b0, "busy in reset");
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R7: start bit of 0xFF is the only low stretch
        begin
            int w = 0;
            send(8'hFF);
            while (tx == 1'b0) begin
                w++;
                @(negedge clk);
            end
            chk("R7", w, CPB, "start bit width in cycles");
        end
        wait_idle();

        // R9: 8N1, 0x41 twice back to back
        begin
            bit ref_bits[20] = '{0,1,0,0,0,0,0,1,0,1, 0,1,0,0,0,0,0,1,0,1};
            cap_q.delete();
            sm_len = 10;
            cap_en = 1'b1;
            send(8'h41);
            send(8'h41);
            wait_idle();
            cap_en = 1'b0;
            chk("R9", cap_q.size(), 20, "sampled bit count");
            for (int i = 0; i < 20 && i < cap_q.size(); i++)
                chk("R9", cap_q[i], ref_bits[i], $sformatf("line bit %0d", i));
        end

        // R4: even parity
        par_mode = 2'b01;
        cap_q.delete();
        sm_len = 11;
        cap_en = 1'b1;
        send(8'h41);
        send(8'h03);
        send(8'h00);
        wait_idle();
        cap_en = 1'b0;
        chk("R4", cap_q.size(), 33, "even sample count");
        if (cap_q.size() >= 33) check_parity(1'b0, 3);

        // R4: odd parity
        par_mode = 2'b10;
        cap_q.delete();
        cap_en = 1'b1;
        send(8'h41);
        send(8'hFE);
        send(8'h00);
        wait_idle();
        cap_en = 1'b0;
        chk("R4", cap_q.size(), 33, "odd sample count");
        if (cap_q.size() >= 33) check_parity(1'b1, 3);

        // R5: two stop bits, back to back
        par_mode = 2'b00;
        stop_two = 1'b1;
        send(8'hA5);
        send(8'h5A);
        wait_idle();
        stop_two = 1'b0;

        // R4: reserved code behaves as no parity
        par_mode = 2'b11;
        send(8'h3C);
        wait_idle();
        par_mode = 2'b00;

        // R6: stray valid pulse during a busy frame is dropped
        send(8'h81);
        repeat (5) @(negedge clk);
        chk("R6", in_ready, 1'b0, "ready low while busy");
        in_data  = 8'h00;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        repeat (2 * CPB) @(negedge clk);
        chk("R6", tx, 1'b1, "no frame from dropped pulse");

        // R3: data changed during a frame does not alter it
        send(8'h96);
        in_data = 8'h69;
        wait_idle();

        // R8: reset in the middle of a frame
        send(8'h00);
        repeat (3 * CPB) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8", tx, 1'b1, "tx after mid-frame reset");
        chk("R8", in_ready, 1'b1, "ready after mid-frame reset");
        chk("R8", busy, 1'b0, "busy after mid-frame reset");
        repeat (12 * CPB) @(negedge clk);
        chk("R8", tx, 1'b1, "line stays idle after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule